// File: doc/BRIEF.md
# Partial Scan Register Bank

This block is a bank of N state flip-flops in which only some of the flops join a single serial scan chain. A compile-time bit-mask picks the scanned flops, and a compile-time table of chain positions sets the order in which they are linked. The order lets flops that tests must set often sit near the serial input, and flops that tests must read often sit near the serial output.

With the mode input low, every flop loads its bit of the functional next-state vector. With the mode input high, the scanned flops move data one position from the serial input toward the serial output on each clock, and the unscanned flops keep their value. The hold uses a recirculating enable, not a gated clock. The serial output always shows the last flop in the chain, so a value captured in functional mode can be shifted out afterwards. If the mask selects no flop, the serial output is the serial input delayed by one register that advances only in shift mode.

Top module: `pscan_bank`

## Requirements
- R1: A clock edge with `rst` high clears every bit of `state` and drives `scan_out` to 0.
- R2: With `rst` low and `scan_mode` = 0, each bit of `state` takes its bit of `next_state` on the clock edge.
- R3: With `rst` low and `scan_mode` = 1, every flop whose bit of `SCAN_MASK` is 0 keeps its value, and `next_state` has no effect.
- R4: With `rst` low and `scan_mode` = 1, the scanned flop with chain position 0 takes `scan_in` on the clock edge.
- R5: With `rst` low and `scan_mode` = 1, the scanned flop with chain position p > 0 takes the value that the scanned flop at position p-1 held before the edge.
- R6: When at least one flop is scanned, `scan_out` equals the scanned flop with the highest chain position, in both modes.
- R7: The position of flop i is the 8-bit field `CHAIN_POS[8*i+7:8*i]`. Fields of unscanned flops are ignored. With the default parameters the flops are scanned in the order 7, 2, 4, 1, 5 (flop 7 next to `scan_in`, flop 5 driving `scan_out`), and flops 0, 3 and 6 are unscanned.
- R8: When `SCAN_MASK` is all zero, `scan_out` shows the `scan_in` value sampled at the previous shift-mode edge and holds in functional mode.
- R9: Reset wins over shift mode: `rst` high with `scan_mode` = 1 still clears all flops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_mode | input | 1 | 0 = functional load, 1 = serial shift |
| scan_in | input | 1 | Serial input to chain position 0 |
| next_state | input | N | Functional next-state vector |
| state | output | N | Stored flop values |
| scan_out | output | 1 | Serial output from the last chain position |

## Verification
The assertions check these rules on every clock: the functional load, the freeze of unscanned flops in shift mode, the transfer from each chain position to the next including the head from `scan_in`, the link from the tail flop to `scan_out`, and reset priority. Only the bench scenarios can show that the chain has the intended order end to end. They do this by capturing a known word, shifting it out bit by bit, and shifting a new pattern into the chain. A second instance with an empty mask covers the single-stage pass-through, which the default build does not elaborate.

// File: rtl/pscan_pkg.sv
package pscan_pkg;

    localparam int MAXN  = 64;
    localparam int POS_W = 8;

    typedef enum logic {
        MODE_FUNC  = 1'b0,
        MODE_SHIFT = 1'b1
    } scan_mode_e;

    // Index of the scanned flop at chain position p, or -1 when none.
    function automatic int flop_at(
        input logic [MAXN-1:0]       mask,
        input logic [MAXN*POS_W-1:0] pos,
        input int                    n,
        input int                    p
    );
        int found;
        found = -1;
        for (int i = 0; i < n; i++) begin
            if (mask[i] && (int'(pos[i*POS_W +: POS_W]) == p)) begin
                found = i;
            end
        end
        return found;
    endfunction

endpackage

// File: rtl/pscan_route.sv
module pscan_route
    import pscan_pkg::*;
#(
    parameter int                   N         = 8,
    parameter logic [N-1:0]         SCAN_MASK = '0,
    parameter logic [N*POS_W-1:0]   CHAIN_POS = '0
) (
    input  logic [N-1:0] cur_q,
    input  logic         scan_in,
    output logic [N-1:0] shift_src
);

    for (genvar i = 0; i < N; i++) begin : g_src
        if (SCAN_MASK[i]) begin : g_chained
            localparam int POS = int'(CHAIN_POS[i*POS_W +: POS_W]);
            if (POS == 0) begin : g_head
                assign shift_src[i] = scan_in;
            end else begin : g_link
                localparam int PRED = flop_at(MAXN'(SCAN_MASK), (MAXN*POS_W)'(CHAIN_POS), N, POS - 1);
                assign shift_src[i] = cur_q[PRED];
            end
        end else begin : g_frozen
            assign shift_src[i] = cur_q[i];
        end
    end

endmodule

// File: rtl/pscan_bypass.sv
module pscan_bypass
    import pscan_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic scan_mode,
    input  logic scan_in,
    output logic scan_out
);

    logic byp_d, byp_q;

    always_comb begin
        byp_d = byp_q;
        if (rst) begin
            byp_d = 1'b0;
        end else if (scan_mode == MODE_SHIFT) begin
            byp_d = scan_in;
        end
    end

    always_ff @(posedge clk) begin
        byp_q <= byp_d;
    end

    assign scan_out = byp_q;

    AST_BYPASS_SHIFT: assert property (@(posedge clk) disable iff (rst)
        scan_mode |=> (scan_out == $past(scan_in))); // R8
    AST_BYPASS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !scan_mode |=> $stable(scan_out)); // R8

endmodule

// File: rtl/pscan_bank.sv
module pscan_bank
    import pscan_pkg::*;
#(
    parameter int                 N         = 8,
    parameter logic [N-1:0]       SCAN_MASK = 8'b1011_0110,
    parameter logic [N*POS_W-1:0] CHAIN_POS = {8'd0, 8'hFF, 8'd4, 8'd2, 8'hFF, 8'd1, 8'd3, 8'hFF}
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         scan_mode,
    input  logic         scan_in,
    input  logic [N-1:0] next_state,
    output logic [N-1:0] state,
    output logic         scan_out
);

    localparam int NSCAN  = $countones(SCAN_MASK);
    localparam int TAIL_R = (NSCAN > 0) ? flop_at(MAXN'(SCAN_MASK), (MAXN*POS_W)'(CHAIN_POS), N, NSCAN - 1) : 0;
    localparam int TAIL   = (TAIL_R < 0) ? 0 : TAIL_R;

    typedef struct packed {
        logic [N-1:0] flops;
    } bank_t;

    bank_t        bank_d, bank_q;
    logic [N-1:0] shift_src;

    pscan_route #(
        .N         (N),
        .SCAN_MASK (SCAN_MASK),
        .CHAIN_POS (CHAIN_POS)
    ) u_route (
        .cur_q     (bank_q.flops),
        .scan_in   (scan_in),
        .shift_src (shift_src)
    );

    always_comb begin
        bank_d = bank_q;
        if (rst) begin
            bank_d.flops = '0;
        end else if (scan_mode == MODE_SHIFT) begin
            bank_d.flops = shift_src;
        end else begin
            bank_d.flops = next_state;
        end
    end

    always_ff @(posedge clk) begin
        bank_q <= bank_d;
    end

    assign state = bank_q.flops;

    if (NSCAN == 0) begin : g_no_chain
        pscan_bypass u_byp (
            .clk       (clk),
            .rst       (rst),
            .scan_mode (scan_mode),
            .scan_in   (scan_in),
            .scan_out  (scan_out)
        );
    end else begin : g_chain_out
        assign scan_out = bank_q.flops[TAIL];

        AST_TAIL_CAPTURE: assert property (@(posedge clk) disable iff (rst)
            !scan_mode |=> (scan_out == $past(next_state[TAIL]))); // R6
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (state == '0)); // R1
    AST_RESET_OVER_SHIFT: assert property (@(posedge clk)
        (rst && scan_mode) |=> (state == '0)); // R9
    AST_FUNC_LOAD: assert property (@(posedge clk) disable iff (rst)
        !scan_mode |=> (state == $past(next_state))); // R2
    AST_UNSCANNED_FROZEN: assert property (@(posedge clk) disable iff (rst)
        scan_mode |=> ((state & ~SCAN_MASK) == $past(state & ~SCAN_MASK))); // R3

    for (genvar i = 0; i < N; i++) begin : g_chk
        if (SCAN_MASK[i]) begin : g_scanned
            localparam int POS = int'(CHAIN_POS[i*POS_W +: POS_W]);
            if (POS == 0) begin : g_head
                AST_HEAD_TAKES_IN: assert property (@(posedge clk) disable iff (rst)
                    scan_mode |=> (state[i] == $past(scan_in))); // R4
            end else begin : g_link
                localparam int PRED = flop_at(MAXN'(SCAN_MASK), (MAXN*POS_W)'(CHAIN_POS), N, POS - 1);
                AST_CHAIN_ADVANCE: assert property (@(posedge clk) disable iff (rst)
                    scan_mode |=> (state[i] == $past(state[PRED]))); // R5
            end
        end
    end

endmodule

// File: tb/sim_pscan_bank.sv
module sim_pscan_bank;

    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         scan_mode = 1'b0;
    logic         scan_in = 1'b0;
    logic [N-1:0] next_state = '0;
    logic [N-1:0] state0, state1;
    logic         so0, so1;

    always #(CLK_PERIOD/2) clk = ~clk;

    pscan_bank u0 (
        .clk (clk), .rst (rst), .scan_mode (scan_mode), .scan_in (scan_in),
        .next_state (next_state), .state (state0), .scan_out (so0)
    );

    pscan_bank #(.N(N), .SCAN_MASK('0), .CHAIN_POS('0)) u1 (
        .clk (clk), .rst (rst), .scan_mode (scan_mode), .scan_in (scan_in),
        .next_state (next_state), .state (state1), .scan_out (so1)
    );

    typedef struct {
        logic [N-1:0] st0;
        logic         so0;
        logic [N-1:0] st1;
        logic         so1;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;

    // Independent model. R7: chain order 7,2,4,1,5; flops 0,3,6 unscanned.
    logic [N-1:0] m_st0 = '0;
    logic [N-1:0] m_st1 = '0;
    logic         m_so1 = 1'b0;

    task automatic step(input logic r, input logic mode, input logic si, input logic [N-1:0] d);
        logic [N-1:0] nx;
        exp_t e;
        string tag;
        @(negedge clk);
        rst = r; scan_mode = mode; scan_in = si; next_state = d;
        if (r) begin
            m_st0 = '0; m_st1 = '0; m_so1 = 1'b0;
            tag = mode ? "R9" : "R1";
        end else if (mode) begin
            nx = m_st0;
            nx[7] = si;
            nx[2] = m_st0[7];
            nx[4] = m_st0[2];
            nx[1] = m_st0[4];
            nx[5] = m_st0[1];
            m_st0 = nx;
            m_so1 = si;
            tag = "R3 R4 R5 R6 R7 R8";
        end else begin
            m_st0 = d;
            m_st1 = d;
            tag = "R2 R6 R8";
        end
        e.st0 = m_st0; e.so0 = m_st0[5]; e.st1 = m_st1; e.so1 = m_so1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                exp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                vectors++;
                if (state0 !== e.st0) begin
                    miscompares++;
                    $display("FAIL %s: state actual %b expected %b", t, state0, e.st0);
                end
                if (so0 !== e.so0) begin
                    miscompares++;
                    $display("FAIL %s: scan_out actual %b expected %b", t, so0, e.so0);
                end
                if (state1 !== e.st1) begin
                    miscompares++;
                    $display("FAIL %s (empty mask): state actual %b expected %b", t, state1, e.st1);
                end
                if (so1 !== e.so1) begin
                    miscompares++;
                    $display("FAIL %s (empty mask): scan_out actual %b expected %b", t, so1, e.so1);
                end
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin : driver
        logic [4:0] pat;
        // R1: reset state
        step(1'b1, 1'b0, 1'b0, 8'hFF);
        step(1'b1, 1'b0, 1'b1, 8'hA5);
        // R2, R6: functional loads under several patterns
        step(1'b0, 1'b0, 1'b0, 8'hA5);
        step(1'b0, 1'b0, 1'b1, 8'h3C);
        step(1'b0, 1'b0, 1'b0, 8'hFF);
        step(1'b0, 1'b0, 1'b0, 8'h00);
        step(1'b0, 1'b0, 1'b0, 8'b1010_0101);
        // R3 R4 R5 R6 R7: shift the captured word out, a new pattern in
        pat = 5'b10110;
        for (int k = 0; k < 5; k++) begin
            step(1'b0, 1'b1, pat[k], 8'hFF);
        end
        // R3: next_state toggles during shift, unscanned flops stay frozen
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 1'b1, k[0], (k[1] ? 8'h55 : 8'hAA));
        end
        // R6: capture then observe on scan_out
        step(1'b0, 1'b0, 1'b0, 8'b0110_1001);
        step(1'b0, 1'b1, 1'b1, 8'h00);
        step(1'b0, 1'b0, 1'b1, 8'hDB);
        // R9: reset while in shift mode
        step(1'b1, 1'b1, 1'b1, 8'hFF);
        step(1'b0, 1'b1, 1'b1, 8'hFF);
        step(1'b0, 1'b1, 1'b1, 8'hFF);
        // R8: empty mask holds in functional mode
        step(1'b0, 1'b0, 1'b0, 8'h81);
        step(1'b0, 1'b1, 1'b0, 8'h7E);
        step(1'b0, 1'b0, 1'b1, 8'h18);
        for (int k = 0; k < 6; k++) begin
            step(1'b0, 1'b1, k[1] ^ k[0], 8'hC3);
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule